// File: doc/BRIEF.md
# Externally Clocked Byte Link Slave

This block is the device side of a byte-wide synchronous serial link in which the far end owns the clock. The incoming serial clock and serial data pins are brought into the system clock domain through two-flop synchronizers. Successive synchronized clock samples are compared to find edges. Each rising edge shifts one received bit in, most significant bit first. Each falling edge drives the next transmit bit onto the serial output.

The host gets one byte and a single-cycle strobe for every eight rising edges. It offers the next outgoing byte through a write port. When no byte is moving, that write goes straight into the transmit shifter. Once a byte has started, the write waits in a one-deep pending slot, which is used at the next byte boundary. If the host has written nothing by then, a programmable filler byte is sent instead.

An idle timer, measured in system clock cycles, discards a partially received byte when the link clock stops for longer than a programmable number of microseconds. This keeps the byte framing aligned with the far end.

Top module: `serial_link_slave`

## Requirements
- R1: On each rising edge of `sclk_in`, the receive shifter moves left by one and takes the synchronized `sdin` into bit 0. After eight rising edges, `rx_data` holds the eight sampled bits, with the first sampled bit in bit 7.
- R2: On each falling edge of `sclk_in`, `sdout` takes bit 7 of the transmit shifter, and the shifter then moves left by one. A loaded byte therefore leaves most significant bit first, with its first bit driven on the falling edge that comes before the byte's first rising edge.
- R3: `rx_valid` is high for exactly one system clock cycle per completed byte, and the bit count wraps from 7 to 0 at that point.
- R4: At byte completion, the pending byte (if its flag is set) is moved into the transmit shifter and the flag is cleared. Otherwise the filler byte (written through `fill_wr`, reset value 0xFF) is loaded.
- R5: If a rising edge arrives more than `tout_us` microseconds (converted with `CLK_FREQ_HZ`) after the previous rising edge, the partial byte and bit count are cleared before that edge's bit is taken. With the timeout set to 10 us, rising edges 36 cycles apart at 4 MHz keep the byte intact.
- R6: The timeout resets to 500 us and can be rewritten at run time through `tout_wr`. Under the default, rising edges spaced 216 cycles apart at 4 MHz do not break a byte.
- R7: A `tx_wr` while the bit count is zero loads the transmit shifter directly and clears the pending flag. A `tx_wr` during a byte only fills the pending slot and leaves the byte in flight unchanged.
- R8: A second `tx_wr` before the pending byte is consumed silently replaces it.
- R9: A change of `clk_src_sel` clears the bit count and the partial receive byte, so that the next eight rising edges form a whole byte.
- R10: Out of reset, `sdout` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the link master (idles high) |
| sdin | input | 1 | Serial data from the link master |
| sdout | output | 1 | Serial data to the link master |
| tx_wr | input | 1 | Host write strobe for the next transmit byte |
| tx_data | input | 8 | Transmit byte |
| fill_wr | input | 1 | Host write strobe for the filler byte |
| fill_data | input | 8 | Filler byte |
| tout_wr | input | 1 | Host write strobe for the idle timeout |
| tout_data | input | TO_W | Idle timeout in microseconds |
| clk_src_sel | input | 1 | Clock-source setting; any change restarts byte framing |
| rx_data | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The bench builds the block with `CLK_FREQ_HZ` set to 4 MHz, so one microsecond equals four system cycles. It sets the link clock half-period to eight cycles. With these values, both the 500 us default and a 10 us timeout written at run time can be exercised in a few hundred cycles. This puts gaps just below the threshold and idle stretches well above it within reach, along with the synchronizer and edge-detect latency between pin activity and `sdout` and `rx_valid`.

// File: rtl/link_slave_pkg.sv
package link_slave_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] pend;
        logic [BYTE_W-1:0] fill;
        logic              pend_v;
        logic [CNT_W-1:0]  cnt;
        logic              sdout;
        logic              rx_valid;
        logic              sclk_prev;
        logic              src;
    } link_state_t;

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/link_idle_timer.sv
module link_idle_timer #(
    parameter int CLK_FREQ_HZ = 16_000_000,
    parameter int TO_W        = 16,
    parameter int TOUT_RST_US = 500,
    parameter int IDLE_W      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            tout_wr,
    input  logic [TO_W-1:0] tout_data,
    output logic            stale
);
    localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;

    typedef struct packed {
        logic [IDLE_W-1:0] cnt;
        logic [TO_W-1:0]   tout;
    } timer_state_t;

    timer_state_t q, d;
    logic [IDLE_W-1:0] limit_cyc;

    always_comb begin
        limit_cyc = {{(IDLE_W-TO_W){1'b0}}, q.tout} * IDLE_W'(CYC_PER_US);
        d = q;
        if (restart)
            d.cnt = '0;
        else if (q.cnt != '1)
            d.cnt = q.cnt + 1'b1;
        if (tout_wr)
            d.tout = tout_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.tout <= TO_W'(TOUT_RST_US);
        end else begin
            q <= d;
        end
    end

    assign stale = (q.cnt > limit_cyc);
endmodule

// File: rtl/serial_link_slave.sv
module serial_link_slave
    import link_slave_pkg::*;
#(
    parameter int          CLK_FREQ_HZ = 16_000_000,
    parameter int          TO_W        = 16,
    parameter int          TOUT_RST_US = 500,
    parameter int          IDLE_W      = 32,
    parameter logic [7:0]  FILL_RST    = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_in,
    input  logic            sdin,
    output logic            sdout,
    input  logic            tx_wr,
    input  logic [7:0]      tx_data,
    input  logic            fill_wr,
    input  logic [7:0]      fill_data,
    input  logic            tout_wr,
    input  logic [TO_W-1:0] tout_data,
    input  logic            clk_src_sel,
    output logic [7:0]      rx_data,
    output logic            rx_valid
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_state_t q, d;
    logic [1:0] pins_s;
    logic sclk_s, sdin_s;
    logic rise_ev, fall_ev, src_chg, stale;
    logic [BYTE_W-1:0] rx_base;
    logic [CNT_W-1:0]  cnt_base;
    logic [CNT_W-1:0]  bit_cnt_w;
    logic              pend_v_w;

    link_sync #(.W(2), .RST_VAL(2'b11)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk_in, sdin}),
        .dout (pins_s)
    );

    assign sclk_s  = pins_s[1];
    assign sdin_s  = pins_s[0];
    assign rise_ev = sclk_s & ~q.sclk_prev;
    assign fall_ev = ~sclk_s & q.sclk_prev;
    assign src_chg = clk_src_sel ^ q.src;

    link_idle_timer #(
        .CLK_FREQ_HZ(CLK_FREQ_HZ),
        .TO_W       (TO_W),
        .TOUT_RST_US(TOUT_RST_US),
        .IDLE_W     (IDLE_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (rise_ev),
        .tout_wr  (tout_wr),
        .tout_data(tout_data),
        .stale    (stale)
    );

    always_comb begin
        d           = q;
        d.rx_valid  = 1'b0;
        d.sclk_prev = sclk_s;
        d.src       = clk_src_sel;
        rx_base     = stale ? '0 : q.rx;
        cnt_base    = stale ? '0 : q.cnt;

        if (src_chg) begin
            d.cnt = '0;
            d.rx  = '0;
        end else if (rise_ev) begin
            d.rx = {rx_base[BYTE_W-2:0], sdin_s};
            if (cnt_base == LAST_BIT) begin
                d.cnt      = '0;
                d.rx_valid = 1'b1;
                if (q.pend_v) begin
                    d.tx     = q.pend;
                    d.pend_v = 1'b0;
                end else begin
                    d.tx = q.fill;
                end
            end else begin
                d.cnt = cnt_base + 1'b1;
            end
        end else if (fall_ev) begin
            d.sdout = q.tx[BYTE_W-1];
            d.tx    = {q.tx[BYTE_W-2:0], 1'b0};
        end

        if (fill_wr)
            d.fill = fill_data;

        if (tx_wr) begin
            if (q.cnt == '0) begin
                d.tx     = tx_data;
                d.pend_v = 1'b0;
            end else begin
                d.pend   = tx_data;
                d.pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.rx        <= '0;
            q.tx        <= '0;
            q.pend      <= '0;
            q.fill      <= FILL_RST;
            q.pend_v    <= 1'b0;
            q.cnt       <= '0;
            q.sdout     <= 1'b0;
            q.rx_valid  <= 1'b0;
            q.sclk_prev <= 1'b1;
            q.src       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sdout     = q.sdout;
    assign rx_data   = q.rx;
    assign rx_valid  = q.rx_valid;
    assign bit_cnt_w = q.cnt;
    assign pend_v_w  = q.pend_v;
endmodule

// File: rtl/link_slave_checker.sv
module link_slave_checker
    import link_slave_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sdout,
    input logic             rx_valid,
    input logic             tx_wr,
    input logic             rise_ev,
    input logic             fall_ev,
    input logic             src_chg,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             pend_v
);
    AST_RX_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise_ev)); // R1

    AST_SDOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdout)); // R2

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

    AST_PEND_USED_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!pend_v || $past(tx_wr))); // R4

    AST_DIRECT_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && bit_cnt == '0) |=> !pend_v); // R7

    AST_MIDBYTE_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && bit_cnt != '0) |=> pend_v); // R8

    AST_SRC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        src_chg |=> (bit_cnt == '0)); // R9

    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sdout && !rx_valid)); // R10
endmodule

bind serial_link_slave link_slave_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdout   (sdout),
    .rx_valid(rx_valid),
    .tx_wr   (tx_wr),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .src_chg (src_chg),
    .bit_cnt (bit_cnt_w),
    .pend_v  (pend_v_w)
);

// File: tb/test_serial_link_slave.sv
module test_serial_link_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int TO_W       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b1, sdin = 1'b1;
    logic tx_wr = 1'b0, fill_wr = 1'b0, tout_wr = 1'b0, clk_src_sel = 1'b0;
    logic [7:0] tx_data = '0, fill_data = '0;
    logic [TO_W-1:0] tout_data = '0;
    logic sdout, rx_valid;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0, n_rx_exp = 0, n_rx_seen = 0;
    logic [7:0] exp_q[$];
    logic prev_valid = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_link_slave #(.CLK_FREQ_HZ(4_000_000), .TO_W(TO_W)) i_serial_link_slave (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdin(sdin), .sdout(sdout),
        .tx_wr(tx_wr), .tx_data(tx_data), .fill_wr(fill_wr), .fill_data(fill_data),
        .tout_wr(tout_wr), .tout_data(tout_data), .clk_src_sel(clk_src_sel),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: pops the scoreboard whenever a byte completes
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_rx_seen++;
            check(!prev_valid, "R3 strobe width", 32'(prev_valid), 0);
            if (exp_q.size() == 0) begin
                check(0, "R1/R5/R9 unexpected byte", 32'(rx_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R1 received byte", 32'(rx_data), 32'(e));
            end
        end
        prev_valid <= rx_valid;
    end

    task automatic bit_xfer(input logic b, input int gap, output logic so);
        sclk_in = 1'b0; sdin = b;
        tick(HALF);
        so = sdout;
        sclk_in = 1'b1;
        tick(HALF + gap);
    endtask

    task automatic push(input logic [7:0] v);
        exp_q.push_back(v);
        n_rx_exp++;
    endtask

    task automatic xfer(input logic [7:0] din, input logic [7:0] exp_out, input bit chk,
                        input int gap, input string tag);
        logic [7:0] got;
        push(din);
        for (int i = 7; i >= 0; i--) bit_xfer(din[i], gap, got[i]);
        if (chk) check(got == exp_out, tag, 32'(got), 32'(exp_out));
    endtask

    task automatic partial(input logic [7:0] din, input int nbits);
        logic so;
        for (int i = 7; i > 7 - nbits; i--) bit_xfer(din[i], 0, so);
    endtask

    task automatic pulse_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] got;
        logic so;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check(sdout == 1'b0, "R10 sdout after reset", 32'(sdout), 0);
        check(rx_valid == 1'b0, "R10 rx_valid after reset", 32'(rx_valid), 0);

        fill_data = 8'h5A; fill_wr = 1'b1; tick(1); fill_wr = 1'b0;
        pulse_tx(8'hA5);
        tick(4);
        xfer(8'h3C, 8'hA5, 1, 0, "R7 direct load / R2 shift out");
        xfer(8'hC3, 8'h5A, 1, 0, "R4 filler when nothing pending");

        // mid-byte writes: current byte untouched, second write replaces first
        push(8'h0F);
        for (int i = 7; i >= 5; i--) bit_xfer(got[i] === 1'bx ? 1'b0 : 1'b0, 0, got[i]);
        pulse_tx(8'h11);
        pulse_tx(8'h22);
        for (int i = 4; i >= 0; i--) bit_xfer((i < 4) ? 1'b1 : 1'b0, 0, got[i]);
        check(got == 8'h5A, "R7 mid-byte write leaves byte in flight", 32'(got), 32'h5A);
        xfer(8'hF0, 8'h22, 1, 0, "R8 pending overwritten by later write");
        xfer(8'h55, 8'h5A, 1, 0, "R4 pending consumed then filler");

        // default 500 us = 2000 cycles; 200-cycle gaps must not resync
        xfer(8'h81, 8'h5A, 1, 200, "R6 default timeout tolerates long gaps");

        // program 10 us = 40 cycles
        tout_data = 16'd10; tout_wr = 1'b1; tick(1); tout_wr = 1'b0;
        partial(8'hFF, 3);
        tick(100);
        xfer(8'h96, 8'h00, 0, 0, "R5");
        xfer(8'h6B, 8'h00, 0, 20, "R5");
        check(exp_q.size() == 0, "R5 partial byte discarded after idle", 32'(exp_q.size()), 0);

        // clock-source change restarts framing
        partial(8'hAA, 4);
        clk_src_sel = 1'b1;
        tick(3);
        xfer(8'h7E, 8'h00, 0, 0, "R9");
        tick(20);
        check(exp_q.size() == 0, "R9 framing restarted after source change", 32'(exp_q.size()), 0);
        check(n_rx_seen == n_rx_exp, "R3 one strobe per byte", 32'(n_rx_seen), 32'(n_rx_exp));
        so = sdout;
        report();
    end
endmodule